// File: doc/BRIEF.md
# Register-Selected ALU and Flag Unit

This block is the execution unit of a small 16-bit processor whose control unit does no ALU decoding. Software loads an accumulator A and two operand registers, B and C, from a shared data bus. A 6-bit select register S holds the ALU operation. The ALU is a chain of four-bit function slices. It always computes a function of A and B, chosen by S. An equality comparator always compares A with C.

The result reaches the bus only when the sequencer asserts its output enable, and A can be driven onto the bus the same way. A 3-bit flag register records carry, equal and not-equal. It changes only when the sequencer pulses the flag-load control, which it does during compare instructions and during instructions that move the ALU result.

The bus is split into a data input, a data output and a drive-enable output, so that a tri-state bus outside the block can be built from them.

Top module: `sel_alu_unit`

## Requirements
- R1: While `rst_n` is low, A, B, C, S and the flag register are zero. Reset is applied asynchronously and released through a two-stage synchronizer, so loads on the first two rising edges after `rst_n` rises are ignored.
- R2: Each of A, B, C and S takes `bus_in` on a rising edge when its own load enable (`ld_a`, `ld_b`, `ld_c`, `ld_s`) is high. S takes `bus_in[5:0]`. Otherwise each register holds its value.
- R3: S encodes the operation as follows: bits [3:0] are the function code, bit 4 is the mode (1 = logic, 0 = arithmetic) and bit 5 is the carry-in. The logic functions for codes 0 to 15 are: ~A, ~(A|B), ~A&B, 0, ~(A&B), ~B, A^B, A&~B, ~A|B, ~(A^B), B, A&B, all ones, A|~B, A|B, A.
- R4: The arithmetic functions for codes 0 to 15 are each followed by "+ cin", modulo 2^16: A, A|B, A|~B, all ones, A+(A&~B), (A|B)+(A&~B), A+~B, (A&~B)+FFFF, A+(A&B), A+B, (A|~B)+(A&B), (A&B)+FFFF, A+A, (A|B)+A, (A|~B)+A, A+FFFF.
- R5: The carry is bit 16 of the 17-bit arithmetic sum. In logic mode the carry is 0.
- R6: The ALU result is combinational. It is valid in the same cycle that A, B and S hold the operands, with no extra register stage.
- R7: `bus_out` carries A when `oe_a` is high. Otherwise it carries the ALU result when `oe_res` is high. Otherwise it is zero. `bus_en` is high exactly when either enable is high.
- R8: The comparator reports equal when A equals C bit for bit. It reports not-equal otherwise.
- R9: The flag register holds carry in bit 0, equal in bit 1 and not-equal in bit 2. On a rising edge with `ld_flg` high it captures the values computed from the register contents before that edge. With `ld_flg` low it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 16 | Data from the shared bus |
| ld_a | input | 1 | Load A from the bus |
| ld_b | input | 1 | Load B from the bus |
| ld_c | input | 1 | Load C from the bus |
| ld_s | input | 1 | Load the select register from bus bits [5:0] |
| ld_flg | input | 1 | Capture carry, equal and not-equal |
| oe_a | input | 1 | Drive A onto the bus |
| oe_res | input | 1 | Drive the ALU result onto the bus |
| bus_out | output | 16 | Data driven toward the bus |
| bus_en | output | 1 | Bus drive enable |
| flags | output | 3 | Flag register {ne, eq, carry} |

## Verification
A register load is visible one rising edge after its enable is sampled. From that point the ALU result and the comparator outputs follow within the same cycle, because the path from the registers to `bus_out` is purely combinational. The flag register lags its `ld_flg` pulse by one edge. Reset release takes two extra edges before any load is accepted. The bench therefore drives inputs just after a falling edge and samples `bus_out` and `flags` at the next falling edge, which is exactly one rising edge after the last load. It then sweeps all 64 select codes over a set of operand pairs chosen to cover carry-out, wrap-around and equality.

// File: rtl/sel_alu_pkg.sv
package sel_alu_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned SLICE_W = 4;
  localparam int unsigned SEL_W   = 6;
  localparam int unsigned FLG_W   = 3;

  localparam int unsigned FLG_CY = 0;
  localparam int unsigned FLG_EQ = 1;
  localparam int unsigned FLG_NE = 2;

  typedef struct packed {
    logic       cin;
    logic       logic_mode;
    logic [3:0] fn;
  } alu_sel_t;
endpackage

// File: rtl/sel_alu_rst_sync.sv
module sel_alu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/sel_alu_slice.sv
module sel_alu_slice #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   fn,
  input  logic         logic_mode,
  input  logic         cin,
  output logic [W-1:0] f,
  output logic         cout
);
  logic [W-1:0] x_term;
  logic [W-1:0] y_term;
  logic [W:0]   sum;

  always_comb begin
    x_term = a | (b & {W{fn[0]}}) | (~b & {W{fn[1]}});
    y_term = (a & b & {W{fn[3]}}) | (a & ~b & {W{fn[2]}});
    sum    = {1'b0, x_term} + {1'b0, y_term} + {{W{1'b0}}, cin};
    if (logic_mode) begin
      f    = ~(x_term ^ y_term);
      cout = 1'b0;
    end else begin
      f    = sum[W-1:0];
      cout = sum[W];
    end
  end
endmodule

// File: rtl/sel_alu_chain.sv
module sel_alu_chain
  import sel_alu_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned SW = SLICE_W
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_sel_t      sel,
  output logic [DW-1:0] result,
  output logic          carry
);
  localparam int unsigned NSL = DW / SW;

  logic [NSL:0] chain;

  assign chain[0] = sel.cin;

  for (genvar g = 0; g < NSL; g++) begin : g_slice
    sel_alu_slice #(.W(SW)) u_slice (
      .a         (a[g*SW +: SW]),
      .b         (b[g*SW +: SW]),
      .fn        (sel.fn),
      .logic_mode(sel.logic_mode),
      .cin       (chain[g]),
      .f         (result[g*SW +: SW]),
      .cout      (chain[g+1])
    );
  end

  assign carry = sel.logic_mode ? 1'b0 : chain[NSL];
endmodule

// File: rtl/sel_alu_eq.sv
module sel_alu_eq #(
  parameter int unsigned DW    = 16,
  parameter int unsigned CHUNK = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          eq,
  output logic          ne
);
  localparam int unsigned NCH = DW / CHUNK;

  logic [NCH-1:0] part_eq;

  for (genvar g = 0; g < NCH; g++) begin : g_chunk
    assign part_eq[g] = (a[g*CHUNK +: CHUNK] == b[g*CHUNK +: CHUNK]);
  end

  assign eq = &part_eq;
  assign ne = ~eq;
endmodule

// File: rtl/sel_alu_unit.sv
module sel_alu_unit
  import sel_alu_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_in,
  input  logic          ld_a,
  input  logic          ld_b,
  input  logic          ld_c,
  input  logic          ld_s,
  input  logic          ld_flg,
  input  logic          oe_a,
  input  logic          oe_res,
  output logic [DW-1:0] bus_out,
  output logic          bus_en,
  output logic [FLG_W-1:0] flags
);
  logic              rst_sn;
  logic [DW-1:0]     a_q, a_d;
  logic [DW-1:0]     b_q, b_d;
  logic [DW-1:0]     c_q, c_d;
  alu_sel_t          s_q, s_d;
  logic [FLG_W-1:0]  flg_q, flg_d;
  logic [DW-1:0]     alu_res;
  logic              alu_cy;
  logic              cmp_eq;
  logic              cmp_ne;

  sel_alu_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_sn(rst_sn)
  );

  sel_alu_chain #(.DW(DW), .SW(SLICE_W)) u_alu (
    .a     (a_q),
    .b     (b_q),
    .sel   (s_q),
    .result(alu_res),
    .carry (alu_cy)
  );

  sel_alu_eq #(.DW(DW), .CHUNK(DW/2)) u_cmp (
    .a (a_q),
    .b (c_q),
    .eq(cmp_eq),
    .ne(cmp_ne)
  );

  always_comb begin
    a_d   = ld_a ? bus_in : a_q;
    b_d   = ld_b ? bus_in : b_q;
    c_d   = ld_c ? bus_in : c_q;
    s_d   = ld_s ? alu_sel_t'(bus_in[SEL_W-1:0]) : s_q;
    flg_d = flg_q;
    if (ld_flg) begin
      flg_d[FLG_CY] = alu_cy;
      flg_d[FLG_EQ] = cmp_eq;
      flg_d[FLG_NE] = cmp_ne;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      a_q   <= '0;
      b_q   <= '0;
      c_q   <= '0;
      s_q   <= '0;
      flg_q <= '0;
    end else begin
      a_q   <= a_d;
      b_q   <= b_d;
      c_q   <= c_d;
      s_q   <= s_d;
      flg_q <= flg_d;
    end
  end

  always_comb begin
    if (oe_a)        bus_out = a_q;
    else if (oe_res) bus_out = alu_res;
    else             bus_out = '0;
    bus_en = oe_a | oe_res;
  end

  assign flags = flg_q;
endmodule

// File: rtl/sel_alu_unit_chk.sv
module sel_alu_unit_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_sn,
  input logic [DW-1:0] bus_in,
  input logic          ld_a,
  input logic          ld_b,
  input logic          ld_flg,
  input logic          oe_a,
  input logic          oe_res,
  input logic [DW-1:0] bus_out,
  input logic          bus_en,
  input logic [2:0]    flags,
  input logic [DW-1:0] a_q,
  input logic [DW-1:0] b_q,
  input logic [DW-1:0] c_q,
  input logic [5:0]    s_q,
  input logic          alu_cy
);
  a_r2_load_a: assert property (@(posedge clk) disable iff (!rst_sn)
    ld_a |=> a_q == $past(bus_in));

  a_r2_load_b: assert property (@(posedge clk) disable iff (!rst_sn)
    ld_b |=> b_q == $past(bus_in));

  a_r5_logic_no_carry: assert property (@(posedge clk) disable iff (!rst_sn)
    s_q[4] |-> !alu_cy);

  a_r7_bus_acc: assert property (@(posedge clk) disable iff (!rst_sn)
    oe_a |-> (bus_out == a_q) && bus_en);

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    !(oe_a || oe_res) |-> (bus_out == '0) && !bus_en);

  a_r8_eq_capture: assert property (@(posedge clk) disable iff (!rst_sn)
    ld_flg |=> flags[1] == ($past(a_q) == $past(c_q)));

  a_r8_ne_opposite: assert property (@(posedge clk) disable iff (!rst_sn)
    ld_flg |=> flags[2] != flags[1]);

  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !ld_flg |=> $stable(flags));
endmodule

bind sel_alu_unit sel_alu_unit_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst_sn (rst_sn),
  .bus_in (bus_in),
  .ld_a   (ld_a),
  .ld_b   (ld_b),
  .ld_flg (ld_flg),
  .oe_a   (oe_a),
  .oe_res (oe_res),
  .bus_out(bus_out),
  .bus_en (bus_en),
  .flags  (flags),
  .a_q    (a_q),
  .b_q    (b_q),
  .c_q    (c_q),
  .s_q    (s_q),
  .alu_cy (alu_cy)
);

// File: tb/sel_alu_unit_test.sv
module sel_alu_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [15:0] bus_in;
  logic        ld_a, ld_b, ld_c, ld_s, ld_flg, oe_a, oe_res;
  logic [15:0] bus_out;
  logic        bus_en;
  logic [2:0]  flags;

  int n_chk;
  int n_bad;
  bit done;

  sel_alu_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in),
    .ld_a(ld_a), .ld_b(ld_b), .ld_c(ld_c), .ld_s(ld_s), .ld_flg(ld_flg),
    .oe_a(oe_a), .oe_res(oe_res),
    .bus_out(bus_out), .bus_en(bus_en), .flags(flags)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected {carry, result} worked out from the R3 and R4 function lists.
  function automatic logic [16:0] model(input logic [5:0] s, input logic [15:0] a,
                                        input logic [15:0] b);
    logic [16:0] r, ci, ea, eb, ones;
    ci   = {16'b0, s[5]};
    ea   = {1'b0, a};
    eb   = {1'b0, b};
    ones = 17'h0FFFF;
    if (s[4]) begin
      case (s[3:0])
        4'd0:  r = {1'b0, ~a};
        4'd1:  r = {1'b0, ~(a | b)};
        4'd2:  r = {1'b0, ~a & b};
        4'd3:  r = 17'h0;
        4'd4:  r = {1'b0, ~(a & b)};
        4'd5:  r = {1'b0, ~b};
        4'd6:  r = {1'b0, a ^ b};
        4'd7:  r = {1'b0, a & ~b};
        4'd8:  r = {1'b0, ~a | b};
        4'd9:  r = {1'b0, ~(a ^ b)};
        4'd10: r = {1'b0, b};
        4'd11: r = {1'b0, a & b};
        4'd12: r = 17'h0FFFF;
        4'd13: r = {1'b0, a | ~b};
        4'd14: r = {1'b0, a | b};
        default: r = {1'b0, a};
      endcase
    end else begin
      case (s[3:0])
        4'd0:  r = ea + ci;
        4'd1:  r = {1'b0, a | b} + ci;
        4'd2:  r = {1'b0, a | ~b} + ci;
        4'd3:  r = ones + ci;
        4'd4:  r = ea + {1'b0, a & ~b} + ci;
        4'd5:  r = {1'b0, a | b} + {1'b0, a & ~b} + ci;
        4'd6:  r = ea + {1'b0, ~b} + ci;
        4'd7:  r = {1'b0, a & ~b} + ones + ci;
        4'd8:  r = ea + {1'b0, a & b} + ci;
        4'd9:  r = ea + eb + ci;
        4'd10: r = {1'b0, a | ~b} + {1'b0, a & b} + ci;
        4'd11: r = {1'b0, a & b} + ones + ci;
        4'd12: r = ea + ea + ci;
        4'd13: r = {1'b0, a | b} + ea + ci;
        4'd14: r = {1'b0, a | ~b} + ea + ci;
        default: r = ea + ones + ci;
      endcase
    end
    return r;
  endfunction

  // which: 0=A 1=B 2=C 3=S 4=flags (bus value ignored)
  task automatic load(input int which, input logic [15:0] v);
    @(negedge clk);
    oe_a = 1'b0; oe_res = 1'b0;
    bus_in = v;
    ld_a = (which == 0); ld_b = (which == 1); ld_c = (which == 2);
    ld_s = (which == 3); ld_flg = (which == 4);
    @(negedge clk);
    ld_a = 1'b0; ld_b = 1'b0; ld_c = 1'b0; ld_s = 1'b0; ld_flg = 1'b0;
  endtask

  task automatic peek_a(output logic [15:0] v);
    oe_a = 1'b1; #1; v = bus_out; oe_a = 1'b0; #1;
  endtask

  initial begin
    logic [15:0] pairs_a [7];
    logic [15:0] pairs_b [7];
    logic [15:0] v;
    logic [16:0] e;
    logic [2:0]  held;
    n_chk = 0; n_bad = 0; done = 0;
    pairs_a = '{16'h0000, 16'hFFFF, 16'h1234, 16'h8000, 16'h5A5A, 16'hFFFF, 16'h7FFF};
    pairs_b = '{16'h0000, 16'h0001, 16'hABCD, 16'h8000, 16'hA5A5, 16'hFFFF, 16'h0001};
    rst_n = 1'b0; bus_in = '0;
    ld_a = 0; ld_b = 0; ld_c = 0; ld_s = 0; ld_flg = 0; oe_a = 0; oe_res = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 flags", {29'b0, flags}, 32'h0);
    peek_a(v); check("R1 A", {16'b0, v}, 32'h0);
    check("R7 idle bus_en", {31'b0, bus_en}, 32'h0);
    // R1: loads during the two synchronizer edges are ignored
    rst_n = 1'b1; bus_in = 16'h1234; ld_a = 1'b1;
    @(negedge clk);
    @(negedge clk);
    ld_a = 1'b0;
    peek_a(v); check("R1 load ignored after release", {16'b0, v}, 32'h0);
    // R1: reset result of B, C and S: A=0,B=0,S=0 gives A+0 = 0, and A equals C
    oe_res = 1'b1; #1;
    check("R1 result after reset", {16'b0, bus_out}, 32'h0);
    check("R7 bus_en res", {31'b0, bus_en}, 32'h1);
    oe_res = 1'b0;
    // R2: A load and hold
    load(0, 16'hBEEF);
    peek_a(v); check("R2 A load", {16'b0, v}, 32'hBEEF);
    @(negedge clk); bus_in = 16'h0F0F; @(negedge clk);
    peek_a(v); check("R2 A hold", {16'b0, v}, 32'hBEEF);
    // R7: A has priority over the result
    oe_a = 1'b1; oe_res = 1'b1; #1;
    check("R7 priority", {16'b0, bus_out}, 32'hBEEF);
    oe_a = 1'b0; oe_res = 1'b0;

    // R3 R4 R5 R6: sweep all selects over the operand pairs
    for (int p = 0; p < 7; p++) begin
      load(0, pairs_a[p]);
      load(1, pairs_b[p]);
      for (int s = 0; s < 64; s++) begin
        load(3, {10'b0, s[5:0]});
        e = model(s[5:0], pairs_a[p], pairs_b[p]);
        oe_res = 1'b1; #1;
        if (s[4]) check("R3 logic result", {16'b0, bus_out}, {16'b0, e[15:0]});
        else      check("R4 R6 arith result", {16'b0, bus_out}, {16'b0, e[15:0]});
        ld_flg = 1'b1;
        @(negedge clk);
        ld_flg = 1'b0; oe_res = 1'b0;
        check("R5 carry flag", {31'b0, flags[0]}, {31'b0, e[16]});
      end
    end

    // R8 R9: comparator into the flags
    load(0, 16'h4242);
    load(2, 16'h4242);
    load(4, 16'h0);
    check("R8 equal", {29'b0, flags[2:1]}, 32'h1);
    load(2, 16'h4243);
    load(4, 16'h0);
    check("R8 not equal", {29'b0, flags[2:1]}, 32'h2);
    // R9: hold when ld_flg low while A, C and S change
    held = flags;
    load(0, 16'hFFFF); load(1, 16'h0001); load(3, 16'h0009); load(2, 16'hFFFF);
    check("R9 hold", {29'b0, flags}, {29'b0, held});
    load(4, 16'h0);
    check("R9 capture eq+carry", {29'b0, flags}, 32'h3);
    // R2: S takes only bus bits [5:0] (0x0FC9 -> 0x09, A+B)
    load(0, 16'h0003); load(1, 16'h0004); load(3, 16'h0FC9);
    oe_res = 1'b1; #1;
    check("R2 S low bits", {16'b0, bus_out}, 32'h7);
    oe_res = 1'b0;
    // R1: reset clears mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    check("R1 flags cleared", {29'b0, flags}, 32'h0);
    peek_a(v); check("R1 A cleared", {16'b0, v}, 32'h0);
    rst_n = 1'b1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule